// File: doc/BRIEF.md
# Temperature Sensor Self-Calibration and Measurement Sequencer

This block is the control state machine of a delay-based on-chip temperature sensor. When reset is released, it first drives a reference pulse into the time-to-digital converter. The pulse lasts a fixed number of reference-clock cycles, so its width does not depend on process, voltage or temperature. The code that the converter returns for this pulse shows how fast the silicon is. The sequencer compares it with two thresholds, places the die in one of three process corners, and latches the pair of slope constants for that corner. One slope covers the range below the calibration point and the other covers the range above it.

Next, the sequencer raises its finish flag. This flag switches the converter input to the temperature-dependent pulse. The sequencer then runs one measurement at the known equilibrium temperature and stores the result as the reference code. After that it raises ready and serves measurement requests. An accepted start enables the temperature pulse path. The returned code is held for the downstream temperature calculator, and a locked flag shows when the calculator reports a valid result. The slopes and the reference code stay on the outputs for the calculator.

Top module: `tsense_cal_seq`

## Requirements
- R1: After reset is released, `ref_pulse_o` is high for exactly REF_CYCLES consecutive cycles. During that time `finish_o`, `tdc_en_o` and `ready_o` are low. All of the flag outputs are low while reset is held.
- R2: The code returned for the reference pulse sets `corner_o`. A code at or below TH_LO gives 2 (worst). A code above TH_LO and at or below TH_HI gives 1 (typical). A code above TH_HI gives 0 (best). The corner then holds until reset.
- R3: `slope_cold_o`/`slope_warm_o` carry the slope pair of the latched corner: SLOPE_COLD_BEST/SLOPE_WARM_BEST, SLOPE_COLD_TYP/SLOPE_WARM_TYP, or SLOPE_COLD_WORST/SLOPE_WARM_WORST.
- R4: In the cycle after the reference code is accepted, `finish_o` rises and `tdc_en_o` rises for the equilibrium measurement. `finish_o` stays high until reset.
- R5: The next `tdc_done_i` stores `tdc_code_i` on `ref_code_o`, and `ready_o` rises in the following cycle. `tdc_en_o` falls in that same cycle. Both `ready_o` and `ref_code_o` hold until reset.
- R6: `start_i` has no effect before `ready_o` is high. The calibration sequence and its timing are unchanged.
- R7: In the idle state with ready high, a start is accepted. In the next cycle `tdc_en_o` is high and `locked_o` is low. `tdc_en_o` stays high until the cycle after `tdc_done_i`.
- R8: The `tdc_done_i` of a measurement loads `meas_code_o` and raises `calc_req_o` in the next cycle. `calc_req_o` stays high until `calc_done_i`. In the cycle after `calc_done_i`, `locked_o` is high and `calc_req_o` is low.
- R9: Some inputs are ignored and change no output. These are `start_i` during a measurement or calculation, `calc_done_i` outside a calculation, and `tdc_done_i` outside the three converter waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Measurement request |
| tdc_code_i | input | CODE_W | Converter output code |
| tdc_done_i | input | 1 | Converter code valid strobe |
| calc_done_i | input | 1 | Calculator result valid strobe |
| ref_pulse_o | output | 1 | Fixed-width reference pulse to the converter |
| finish_o | output | 1 | Corner chosen; converter input selects the temperature pulse |
| tdc_en_o | output | 1 | Enable of the temperature pulse path |
| calc_req_o | output | 1 | Calculator request, held until done |
| ready_o | output | 1 | Calibration complete |
| locked_o | output | 1 | Temperature of the last request is valid |
| corner_o | output | 2 | Process corner: 0 best, 1 typical, 2 worst |
| slope_cold_o | output | SLOPE_W | Slope below the calibration point |
| slope_warm_o | output | SLOPE_W | Slope above the calibration point |
| ref_code_o | output | CODE_W | Code at the equilibrium temperature |
| meas_code_o | output | CODE_W | Code of the last measurement |

## Verification
Each response of the block shows up exactly one register stage after its cause. The corner, slopes, finish and enable appear one cycle after the reference strobe. Ready and the reference code appear one cycle after the equilibrium strobe. Enable and the locked clear appear one cycle after an accepted start. The calculator request appears one cycle after the measurement strobe, and locked one cycle after the calculator strobe. The reference pulse width is counted cycle by cycle. The bench drives every input at a falling edge and reads the outputs at the next falling edge, so each check lands on the cycle in which the result is due. Ignored inputs are driven in every state where they must have no effect. The held outputs are read back in the following cycle.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

  typedef enum logic [2:0] {
    ST_BOOT      = 3'd0,
    ST_REF_PULSE = 3'd1,
    ST_REF_WAIT  = 3'd2,
    ST_EQ_WAIT   = 3'd3,
    ST_IDLE      = 3'd4,
    ST_MEAS      = 3'd5,
    ST_CALC      = 3'd6
  } seq_state_t;

  typedef enum logic [1:0] {
    CORNER_BEST  = 2'd0,
    CORNER_TYP   = 2'd1,
    CORNER_WORST = 2'd2
  } corner_t;

endpackage

// File: rtl/tsense_ref_pulse.sv
module tsense_ref_pulse #(
  parameter int REF_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(REF_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(REF_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = run_i || (cnt_q != '0);

  always_comb begin
    if (run_i) cnt_d = cnt_q + 1'b1;
    else       cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = run_i && (cnt_q == LAST_CNT);
endmodule

// File: rtl/tsense_corner_sel.sv
module tsense_corner_sel
  import tsense_pkg::*;
#(
  parameter int CODE_W           = 13,
  parameter int SLOPE_W          = 8,
  parameter int TH_LO            = 180,
  parameter int TH_HI            = 220,
  parameter int SLOPE_COLD_BEST  = 14,
  parameter int SLOPE_WARM_BEST  = 12,
  parameter int SLOPE_COLD_TYP   = 10,
  parameter int SLOPE_WARM_TYP   = 9,
  parameter int SLOPE_COLD_WORST = 7,
  parameter int SLOPE_WARM_WORST = 6
) (
  input  logic [CODE_W-1:0]  code_i,
  output corner_t            corner_o,
  output logic [SLOPE_W-1:0] slope_cold_o,
  output logic [SLOPE_W-1:0] slope_warm_o
);
  localparam logic [CODE_W-1:0] TH_LO_C = CODE_W'(TH_LO);
  localparam logic [CODE_W-1:0] TH_HI_C = CODE_W'(TH_HI);

  // A slower die packs fewer delay stages into the fixed pulse: lower code.
  // A tie with a threshold falls to the slower side.
  always_comb begin
    if (code_i <= TH_LO_C)      corner_o = CORNER_WORST;
    else if (code_i <= TH_HI_C) corner_o = CORNER_TYP;
    else                        corner_o = CORNER_BEST;
  end

  always_comb begin
    unique case (corner_o)
      CORNER_BEST: begin
        slope_cold_o = SLOPE_W'(SLOPE_COLD_BEST);
        slope_warm_o = SLOPE_W'(SLOPE_WARM_BEST);
      end
      CORNER_TYP: begin
        slope_cold_o = SLOPE_W'(SLOPE_COLD_TYP);
        slope_warm_o = SLOPE_W'(SLOPE_WARM_TYP);
      end
      default: begin
        slope_cold_o = SLOPE_W'(SLOPE_COLD_WORST);
        slope_warm_o = SLOPE_W'(SLOPE_WARM_WORST);
      end
    endcase
  end
endmodule

// File: rtl/tsense_seq_fsm.sv
module tsense_seq_fsm
  import tsense_pkg::*;
#(
  parameter int CODE_W  = 13,
  parameter int SLOPE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CODE_W-1:0]  tdc_code_i,
  input  logic               tdc_done_i,
  input  logic               calc_done_i,
  input  logic               pulse_last_i,
  input  corner_t            corner_i,
  input  logic [SLOPE_W-1:0] slope_cold_i,
  input  logic [SLOPE_W-1:0] slope_warm_i,
  output logic               pulse_run_o,
  output logic               finish_o,
  output logic               tdc_en_o,
  output logic               calc_req_o,
  output logic               ready_o,
  output logic               locked_o,
  output logic [1:0]         corner_o,
  output logic [SLOPE_W-1:0] slope_cold_o,
  output logic [SLOPE_W-1:0] slope_warm_o,
  output logic [CODE_W-1:0]  ref_code_o,
  output logic [CODE_W-1:0]  meas_code_o
);
  seq_state_t         state_q, state_d;
  corner_t            corner_q;
  logic [SLOPE_W-1:0] slope_cold_q, slope_warm_q;
  logic [CODE_W-1:0]  ref_code_q, meas_code_q;
  logic               finish_q, ready_q, locked_q;

  logic cal_load, ref_load, meas_load, accept, calc_end;

  assign cal_load  = (state_q == ST_REF_WAIT) && tdc_done_i;
  assign ref_load  = (state_q == ST_EQ_WAIT)  && tdc_done_i;
  assign meas_load = (state_q == ST_MEAS)     && tdc_done_i;
  assign accept    = (state_q == ST_IDLE)     && start_i;
  assign calc_end  = (state_q == ST_CALC)     && calc_done_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_BOOT:      state_d = ST_REF_PULSE;
      ST_REF_PULSE: if (pulse_last_i) state_d = ST_REF_WAIT;
      ST_REF_WAIT:  if (cal_load)     state_d = ST_EQ_WAIT;
      ST_EQ_WAIT:   if (ref_load)     state_d = ST_IDLE;
      ST_IDLE:      if (accept)       state_d = ST_MEAS;
      ST_MEAS:      if (meas_load)    state_d = ST_CALC;
      ST_CALC:      if (calc_end)     state_d = ST_IDLE;
      default:      state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_BOOT;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corner_q     <= CORNER_WORST;
      slope_cold_q <= '0;
      slope_warm_q <= '0;
      finish_q     <= 1'b0;
    end else if (cal_load) begin
      corner_q     <= corner_i;
      slope_cold_q <= slope_cold_i;
      slope_warm_q <= slope_warm_i;
      finish_q     <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_code_q <= '0;
      ready_q    <= 1'b0;
    end else if (ref_load) begin
      ref_code_q <= tdc_code_i;
      ready_q    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         meas_code_q <= '0;
    else if (meas_load) meas_code_q <= tdc_code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        locked_q <= 1'b0;
    else if (accept)   locked_q <= 1'b0;
    else if (calc_end) locked_q <= 1'b1;
  end

  assign pulse_run_o  = (state_q == ST_REF_PULSE);
  assign tdc_en_o     = (state_q == ST_EQ_WAIT) || (state_q == ST_MEAS);
  assign calc_req_o   = (state_q == ST_CALC);
  assign finish_o     = finish_q;
  assign ready_o      = ready_q;
  assign locked_o     = locked_q;
  assign corner_o     = corner_q;
  assign slope_cold_o = slope_cold_q;
  assign slope_warm_o = slope_warm_q;
  assign ref_code_o   = ref_code_q;
  assign meas_code_o  = meas_code_q;
endmodule

// File: rtl/tsense_cal_seq.sv
module tsense_cal_seq
  import tsense_pkg::*;
#(
  parameter int CODE_W           = 13,
  parameter int SLOPE_W          = 8,
  parameter int REF_CYCLES       = 8,
  parameter int TH_LO            = 180,
  parameter int TH_HI            = 220,
  parameter int SLOPE_COLD_BEST  = 14,
  parameter int SLOPE_WARM_BEST  = 12,
  parameter int SLOPE_COLD_TYP   = 10,
  parameter int SLOPE_WARM_TYP   = 9,
  parameter int SLOPE_COLD_WORST = 7,
  parameter int SLOPE_WARM_WORST = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CODE_W-1:0]  tdc_code_i,
  input  logic               tdc_done_i,
  input  logic               calc_done_i,
  output logic               ref_pulse_o,
  output logic               finish_o,
  output logic               tdc_en_o,
  output logic               calc_req_o,
  output logic               ready_o,
  output logic               locked_o,
  output logic [1:0]         corner_o,
  output logic [SLOPE_W-1:0] slope_cold_o,
  output logic [SLOPE_W-1:0] slope_warm_o,
  output logic [CODE_W-1:0]  ref_code_o,
  output logic [CODE_W-1:0]  meas_code_o
);
  logic               pulse_run, pulse_last;
  corner_t            corner_raw;
  logic [SLOPE_W-1:0] cold_raw, warm_raw;

  tsense_ref_pulse #(.REF_CYCLES(REF_CYCLES)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (pulse_run),
    .last_o (pulse_last)
  );

  tsense_corner_sel #(
    .CODE_W(CODE_W), .SLOPE_W(SLOPE_W), .TH_LO(TH_LO), .TH_HI(TH_HI),
    .SLOPE_COLD_BEST(SLOPE_COLD_BEST),   .SLOPE_WARM_BEST(SLOPE_WARM_BEST),
    .SLOPE_COLD_TYP(SLOPE_COLD_TYP),     .SLOPE_WARM_TYP(SLOPE_WARM_TYP),
    .SLOPE_COLD_WORST(SLOPE_COLD_WORST), .SLOPE_WARM_WORST(SLOPE_WARM_WORST)
  ) u_corner (
    .code_i       (tdc_code_i),
    .corner_o     (corner_raw),
    .slope_cold_o (cold_raw),
    .slope_warm_o (warm_raw)
  );

  tsense_seq_fsm #(.CODE_W(CODE_W), .SLOPE_W(SLOPE_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .tdc_code_i   (tdc_code_i),
    .tdc_done_i   (tdc_done_i),
    .calc_done_i  (calc_done_i),
    .pulse_last_i (pulse_last),
    .corner_i     (corner_raw),
    .slope_cold_i (cold_raw),
    .slope_warm_i (warm_raw),
    .pulse_run_o  (pulse_run),
    .finish_o     (finish_o),
    .tdc_en_o     (tdc_en_o),
    .calc_req_o   (calc_req_o),
    .ready_o      (ready_o),
    .locked_o     (locked_o),
    .corner_o     (corner_o),
    .slope_cold_o (slope_cold_o),
    .slope_warm_o (slope_warm_o),
    .ref_code_o   (ref_code_o),
    .meas_code_o  (meas_code_o)
  );

  assign ref_pulse_o = pulse_run;
endmodule

// File: rtl/tsense_cal_seq_chk.sv
module tsense_cal_seq_chk #(
  parameter int CODE_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              calc_done_i,
  input logic              ref_pulse_o,
  input logic              finish_o,
  input logic              tdc_en_o,
  input logic              calc_req_o,
  input logic              ready_o,
  input logic              locked_o,
  input logic [1:0]        corner_o,
  input logic [CODE_W-1:0] ref_code_o
);
  assert_pulse_before_finish_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse_o |-> (!finish_o && !tdc_en_o && !ready_o));

  assert_corner_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |-> (corner_o != 2'd3));

  assert_corner_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |=> $stable(corner_o));

  assert_finish_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |=> finish_o);

  assert_ready_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> (ready_o && $stable(ref_code_o)));

  assert_ready_after_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> finish_o);

  assert_no_enable_before_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !finish_o |-> !tdc_en_o);

  assert_accept_clears_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !tdc_en_o && !calc_req_o && start_i) |=> (tdc_en_o && !locked_o));

  assert_locked_after_calc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_req_o && calc_done_i) |=> (locked_o && !calc_req_o));

  assert_paths_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tdc_en_o && calc_req_o));
endmodule

bind tsense_cal_seq tsense_cal_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .calc_done_i (calc_done_i),
  .ref_pulse_o (ref_pulse_o),
  .finish_o    (finish_o),
  .tdc_en_o    (tdc_en_o),
  .calc_req_o  (calc_req_o),
  .ready_o     (ready_o),
  .locked_o    (locked_o),
  .corner_o    (corner_o),
  .ref_code_o  (ref_code_o)
);

// File: tb/tb_tsense_cal_seq.sv
`timescale 1ns/1ps
module tb_tsense_cal_seq;
  localparam int CODE_W = 13, SLOPE_W = 8, REF_CYCLES = 8;
  localparam int TH_LO = 180, TH_HI = 220;
  localparam int SCB = 14, SWB = 12, SCT = 10, SWT = 9, SCW = 7, SWW = 6;

  logic clk = 1'b0;
  logic rst_n, start_i, tdc_done_i, calc_done_i;
  logic [CODE_W-1:0] tdc_code_i;
  logic ref_pulse_o, finish_o, tdc_en_o, calc_req_o, ready_o, locked_o;
  logic [1:0] corner_o;
  logic [SLOPE_W-1:0] slope_cold_o, slope_warm_o;
  logic [CODE_W-1:0] ref_code_o, meas_code_o;

  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  tsense_cal_seq #(
    .CODE_W(CODE_W), .SLOPE_W(SLOPE_W), .REF_CYCLES(REF_CYCLES),
    .TH_LO(TH_LO), .TH_HI(TH_HI),
    .SLOPE_COLD_BEST(SCB), .SLOPE_WARM_BEST(SWB),
    .SLOPE_COLD_TYP(SCT), .SLOPE_WARM_TYP(SWT),
    .SLOPE_COLD_WORST(SCW), .SLOPE_WARM_WORST(SWW)
  ) dut (.*);

  function automatic int exp_corner(int code);
    if (code <= TH_LO) return 2;
    if (code <= TH_HI) return 1;
    return 0;
  endfunction

  function automatic int exp_cold(int c);
    return (c == 0) ? SCB : (c == 1) ? SCT : SCW;
  endfunction

  function automatic int exp_warm(int c);
    return (c == 0) ? SWB : (c == 1) ? SWT : SWW;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic calibrate(input int code_ref, input int code_eq, input bit hold_start);
    int width;
    bit seen;
    rst_n = 1'b0; start_i = 1'b0; tdc_done_i = 1'b0; calc_done_i = 1'b0; tdc_code_i = '0;
    repeat (3) tick();
    chk(!ref_pulse_o && !finish_o && !ready_o && !tdc_en_o && !locked_o && !calc_req_o,
        "R1 reset flags", {ref_pulse_o, finish_o, ready_o, tdc_en_o, locked_o}, 0);
    start_i = hold_start;   // R6: start held through calibration
    rst_n = 1'b1;
    width = 0; seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (ref_pulse_o) begin
        seen = 1'b1; width++;
        if (tdc_en_o || finish_o || ready_o) chk(1'b0, "R1 flags during pulse", 1, 0);
      end else if (seen) break;
    end
    chk(width == REF_CYCLES, "R1 pulse width", width, REF_CYCLES);
    tick(); tick();
    chk(!finish_o && !tdc_en_o && !ready_o, "R6 no progress before ref code",
        {finish_o, tdc_en_o, ready_o}, 0);
    tdc_code_i = CODE_W'(code_ref); tdc_done_i = 1'b1;
    tick();
    tdc_done_i = 1'b0; tdc_code_i = '0;
    chk(finish_o == 1'b1, "R4 finish rises", finish_o, 1);
    chk(tdc_en_o == 1'b1, "R4 equilibrium enable", tdc_en_o, 1);
    chk(int'(corner_o) == exp_corner(code_ref), "R2 corner", corner_o, exp_corner(code_ref));
    chk(int'(slope_cold_o) == exp_cold(exp_corner(code_ref)), "R3 cold slope",
        slope_cold_o, exp_cold(exp_corner(code_ref)));
    chk(int'(slope_warm_o) == exp_warm(exp_corner(code_ref)), "R3 warm slope",
        slope_warm_o, exp_warm(exp_corner(code_ref)));
    repeat (3) tick();
    chk(!ready_o && tdc_en_o, "R6 ready still low with start held", ready_o, 0);
    start_i = 1'b0;
    tdc_code_i = CODE_W'(code_eq); tdc_done_i = 1'b1;
    tick();
    tdc_done_i = 1'b0; tdc_code_i = '0;
    chk(ready_o == 1'b1, "R5 ready rises", ready_o, 1);
    chk(int'(ref_code_o) == code_eq, "R5 reference code", ref_code_o, code_eq);
    chk(tdc_en_o == 1'b0, "R5 enable falls", tdc_en_o, 0);
    chk(int'(corner_o) == exp_corner(code_ref), "R2 corner held", corner_o, exp_corner(code_ref));
    chk(finish_o == 1'b1, "R4 finish held", finish_o, 1);
  endtask

  task automatic measure(input int code, input int conv_lat, input int calc_lat,
                         input bit noisy, input int ref_exp);
    int prev_meas;
    prev_meas = int'(meas_code_o);
    chk(!tdc_en_o && !calc_req_o, "R7 idle before start", tdc_en_o, 0);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk(tdc_en_o == 1'b1, "R7 enable after start", tdc_en_o, 1);
    chk(locked_o == 1'b0, "R7 locked cleared", locked_o, 0);
    for (int i = 0; i < conv_lat; i++) begin
      if (noisy) begin start_i = 1'b1; calc_done_i = 1'b1; end
      tick();
      start_i = 1'b0; calc_done_i = 1'b0;
      chk(tdc_en_o && !locked_o && !calc_req_o, "R9 noise during conversion", locked_o, 0);
      chk(int'(meas_code_o) == prev_meas, "R9 code held during conversion", meas_code_o, prev_meas);
    end
    tdc_code_i = CODE_W'(code); tdc_done_i = 1'b1;
    tick();
    tdc_done_i = 1'b0; tdc_code_i = '0;
    chk(!tdc_en_o, "R7 enable falls after done", tdc_en_o, 0);
    chk(calc_req_o == 1'b1, "R8 calc request", calc_req_o, 1);
    chk(int'(meas_code_o) == code, "R8 measured code", meas_code_o, code);
    for (int i = 0; i < calc_lat; i++) begin
      if (noisy) begin
        start_i = 1'b1; tdc_done_i = 1'b1; tdc_code_i = CODE_W'(code ^ 13'h0a5);
      end
      tick();
      start_i = 1'b0; tdc_done_i = 1'b0; tdc_code_i = '0;
      chk(calc_req_o && !tdc_en_o && !locked_o, "R9 noise during calculation", calc_req_o, 1);
      chk(int'(meas_code_o) == code, "R9 measured code held", meas_code_o, code);
    end
    start_i = noisy;   // start together with calc_done is ignored
    calc_done_i = 1'b1;
    tick();
    calc_done_i = 1'b0; start_i = 1'b0;
    chk(locked_o == 1'b1, "R8 locked rises", locked_o, 1);
    chk(calc_req_o == 1'b0, "R8 calc request drops", calc_req_o, 0);
    if (noisy) begin
      tdc_done_i = 1'b1; tdc_code_i = CODE_W'(code + 7);
    end
    tick();
    tdc_done_i = 1'b0; tdc_code_i = '0;
    chk(!tdc_en_o && locked_o, "R9 no queued start", tdc_en_o, 0);
    chk(int'(meas_code_o) == code && int'(ref_code_o) == ref_exp,
        "R9 idle strobe ignored", meas_code_o, code);
  endtask

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cal_codes[6];
    int eq, code;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; start_i = 1'b0; tdc_done_i = 1'b0; calc_done_i = 1'b0; tdc_code_i = '0;
    cal_codes = '{TH_LO - 1, TH_LO, TH_LO + 1, TH_HI, TH_HI + 1, 0};
    cal_codes[5] = int'($urandom_range(100, 300));
    foreach (cal_codes[k]) begin
      eq = int'($urandom_range(1500, 2300));
      calibrate(cal_codes[k], eq, k[0]);
      for (int m = 0; m < 6; m++) begin
        code = int'($urandom_range(0, (1 << CODE_W) - 1));
        measure(code, int'($urandom_range(0, 4)), int'($urandom_range(0, 3)),
                (m % 2) == 1, eq);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule